// File: doc/BRIEF.md
# Packed 16-bit Lane Adder/Subtractor with Saturation

This block treats each operand word as a row of 16-bit lanes. It adds or subtracts every lane pair in one pass of a single full-width adder. When the unit is partitioned, the carry chain of that adder is broken at every lane boundary, so a carry or a borrow out of one lane never reaches the lane above it. A two-bit mode input picks how a lane result that falls outside its range is treated: it can wrap modulo 2^16, it can clamp to the signed range, or it can clamp to the unsigned range when a signed operand meets an unsigned one. An op input picks add or subtract.

A per-lane flag output shows which lanes were clamped. An optional output register, with its own valid strobe, places the result one clock after the inputs. With partitioning turned off by a parameter, the same chain behaves as one plain full-width adder/subtractor. A test uses that setting to show that lanes are cut only in packed operation.

Top module: `psa_addsub`

## Requirements
- R1: While rst_n is low, out_valid, result and sat_flags are all zero.
- R2: With the default output register, out_valid equals in_valid of the previous clock. result and sat_flags load only on a clock where in_valid is high and hold their value otherwise.
- R3: With PARTITION=1, the carry (add) or borrow (subtract) out of lane i has no effect on lane i+1. Lane i occupies bits [16i+15:16i].
- R4: In mode 2'b00 (wrap), each lane result is (a op b) mod 2^16, where op is add when op_sub=0 and subtract when op_sub=1.
- R5: In mode 2'b01 (signed saturation), lanes are two's complement in -32768..32767. A result above the range gives 16'h7FFF and a result below it gives 16'h8000.
- R6: In mode 2'b01 with op_sub=0, a lane whose two operands differ in sign bit never saturates. A positive clamp needs both operands non-negative.
- R7: In mode 2'b10 (unsigned saturation), the a lane is signed, the b lane is unsigned (0..65535), and a±b clamps to 16'h0000 below 0 and to 16'hFFFF above 65535.
- R8: A sat_flags bit is 1 exactly when its lane was clamped. All flags are 0 in modes 2'b00 and 2'b11.
- R9: Mode 2'b11 behaves the same as mode 2'b00.
- R10: With PARTITION=0, the unit is a full-width wrap adder/subtractor: carries cross lane boundaries, mode is ignored and sat_flags is 0.
- R11: In mode 2'b10, adding b=0 sets every negative a lane to 0 and passes every non-negative a lane through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract (a - b) |
| mode | input | 2 | 00 wrap, 01 signed sat, 10 unsigned sat, 11 wrap |
| opa | input | LANES*16 | Packed operand a |
| opb | input | LANES*16 | Packed operand b |
| out_valid | output | 1 | Result valid |
| result | output | LANES*16 | Packed lane results |
| sat_flags | output | LANES | Per-lane clamp indicator |

## Verification
The checker watches every cycle for the following: out_valid tracks in_valid, the outputs hold while idle, and the wrap modes never raise a flag. It also checks that in signed-saturation add a lane with mixed-sign operands is never flagged and two non-negative operands never give a negative lane, and that a flagged lane in either saturating mode holds one of its two clamp values. Only the bench's vectors can show that the clamp values, the wrapped sums and the zero/pass-through cases are numerically correct and that each lane stays isolated from its neighbours. The bench also uses a second, unpartitioned instance to show that carries do cross lanes when partitioning is off.

// File: rtl/psa_pkg.sv
package psa_pkg;

    typedef enum logic [1:0] {
        MODE_WRAP     = 2'b00,
        MODE_SSAT     = 2'b01,
        MODE_USAT     = 2'b10,
        MODE_WRAP_ALT = 2'b11
    } psa_mode_e;

endpackage

// File: rtl/psa_lane_add.sv
// One lane slice of the shared carry chain.
module psa_lane_add #(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] bx_i,
    input  logic              cin_i,
    output logic [LANE_W-1:0] sum_o,
    output logic              cout_o
);
    logic [LANE_W:0] full;

    always_comb begin
        full   = {1'b0, a_i} + {1'b0, bx_i} + {{LANE_W{1'b0}}, cin_i};
        sum_o  = full[LANE_W-1:0];
        cout_o = full[LANE_W];
    end
endmodule

// File: rtl/psa_lane_sat.sv
// Per-lane overflow policy, driven from the raw chain outputs.
module psa_lane_sat
    import psa_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic              en_i,
    input  psa_mode_e         mode_i,
    input  logic              sub_i,
    input  logic              a_msb_i,
    input  logic              bx_msb_i,
    input  logic [LANE_W-1:0] sum_i,
    input  logic              cout_i,
    output logic [LANE_W-1:0] res_o,
    output logic              flag_o
);
    localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};
    localparam logic [LANE_W-1:0] UMAX = {LANE_W{1'b1}};
    localparam logic [LANE_W-1:0] UMIN = '0;

    logic       s_pos_ovf;
    logic       s_neg_ovf;
    logic [1:0] hi;
    logic       u_neg;
    logic       u_over;

    always_comb begin
        // Signed: operands agree in sign but sum sign differs.
        s_pos_ovf = !a_msb_i && !bx_msb_i &&  sum_i[LANE_W-1];
        s_neg_ovf =  a_msb_i &&  bx_msb_i && !sum_i[LANE_W-1];
        // Mixed: top two bits of an (LANE_W+2)-bit intermediate.
        hi     = {a_msb_i, a_msb_i} + {sub_i, sub_i} + {1'b0, cout_i};
        u_neg  = hi[1];
        u_over = !hi[1] && hi[0];

        res_o  = sum_i;
        flag_o = 1'b0;
        if (en_i) begin
            unique case (mode_i)
                MODE_SSAT: begin
                    if (s_pos_ovf) begin
                        res_o  = SMAX;
                        flag_o = 1'b1;
                    end else if (s_neg_ovf) begin
                        res_o  = SMIN;
                        flag_o = 1'b1;
                    end
                end
                MODE_USAT: begin
                    if (u_neg) begin
                        res_o  = UMIN;
                        flag_o = 1'b1;
                    end else if (u_over) begin
                        res_o  = UMAX;
                        flag_o = 1'b1;
                    end
                end
                default: begin
                    res_o  = sum_i;
                    flag_o = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/psa_addsub.sv
module psa_addsub
    import psa_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int LANE_W    = 16,
    parameter bit PARTITION = 1'b1,
    parameter bit OUT_REG   = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      op_sub,
    input  logic [1:0]                mode,
    input  logic [LANES*LANE_W-1:0]   opa,
    input  logic [LANES*LANE_W-1:0]   opb,
    output logic                      out_valid,
    output logic [LANES*LANE_W-1:0]   result,
    output logic [LANES-1:0]          sat_flags
);
    localparam int W = LANES * LANE_W;

    typedef struct packed {
        logic             valid;
        logic [W-1:0]     data;
        logic [LANES-1:0] flags;
    } out_t;

    psa_mode_e        mode_e;
    logic [W-1:0]     bx;
    logic [LANES:0]   carry;
    logic [W-1:0]     raw_sum;
    logic [W-1:0]     lane_res;
    logic [LANES-1:0] lane_flag;

    assign mode_e   = psa_mode_e'(mode);
    assign bx       = op_sub ? ~opb : opb;
    assign carry[0] = op_sub;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic cin;
        logic cout;

        if (PARTITION) begin : g_cut
            assign cin = op_sub;
        end else begin : g_chain
            assign cin = carry[i];
        end

        psa_lane_add #(.LANE_W(LANE_W)) u_add (
            .a_i   (opa[i*LANE_W +: LANE_W]),
            .bx_i  (bx[i*LANE_W +: LANE_W]),
            .cin_i (cin),
            .sum_o (raw_sum[i*LANE_W +: LANE_W]),
            .cout_o(cout)
        );
        assign carry[i+1] = cout;

        psa_lane_sat #(.LANE_W(LANE_W)) u_sat (
            .en_i    (PARTITION),
            .mode_i  (mode_e),
            .sub_i   (op_sub),
            .a_msb_i (opa[i*LANE_W + LANE_W-1]),
            .bx_msb_i(bx[i*LANE_W + LANE_W-1]),
            .sum_i   (raw_sum[i*LANE_W +: LANE_W]),
            .cout_i  (cout),
            .res_o   (lane_res[i*LANE_W +: LANE_W]),
            .flag_o  (lane_flag[i])
        );
    end

    out_t out_d;
    out_t out_q;

    if (OUT_REG) begin : g_reg
        always_comb begin
            out_d       = out_q;
            out_d.valid = in_valid;
            if (in_valid) begin
                out_d.data  = lane_res;
                out_d.flags = lane_flag;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q <= '0;
            end else begin
                out_q <= out_d;
            end
        end
    end else begin : g_comb
        always_comb begin
            out_d.valid = in_valid;
            out_d.data  = lane_res;
            out_d.flags = lane_flag;
            out_q       = rst_n ? out_d : '0;
        end
    end

    assign out_valid = out_q.valid;
    assign result    = out_q.data;
    assign sat_flags = out_q.flags;

endmodule

// File: rtl/psa_addsub_chk.sv
module psa_addsub_chk #(
    parameter int LANES     = 4,
    parameter int LANE_W    = 16,
    parameter bit PARTITION = 1'b1,
    parameter bit OUT_REG   = 1'b1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    op_sub,
    input logic [1:0]              mode,
    input logic [LANES*LANE_W-1:0] opa,
    input logic [LANES*LANE_W-1:0] opb,
    input logic                    out_valid,
    input logic [LANES*LANE_W-1:0] result,
    input logic [LANES-1:0]        sat_flags
);
    localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};

    if (OUT_REG) begin : g_seq
        AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid |=> out_valid == $past(in_valid)); // R2

        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(result) && $stable(sat_flags)); // R2

        AST_WRAP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && (mode == 2'b00 || mode == 2'b11) |=> sat_flags == '0); // R8

        if (!PARTITION) begin : g_flat
            AST_FLAT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> sat_flags == '0); // R10
        end else begin : g_lanes
            for (genvar i = 0; i < LANES; i++) begin : g_l
                AST_MIXED_SIGN_NO_SAT: assert property (@(posedge clk) disable iff (!rst_n)
                    in_valid && mode == 2'b01 && !op_sub &&
                    (opa[i*LANE_W+LANE_W-1] != opb[i*LANE_W+LANE_W-1])
                    |=> !sat_flags[i]); // R6

                AST_POS_ADD_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
                    in_valid && mode == 2'b01 && !op_sub &&
                    !opa[i*LANE_W+LANE_W-1] && !opb[i*LANE_W+LANE_W-1]
                    |=> !result[i*LANE_W+LANE_W-1]); // R5

                AST_SSAT_CLAMP_VAL: assert property (@(posedge clk) disable iff (!rst_n)
                    in_valid && mode == 2'b01
                    |=> !sat_flags[i] || result[i*LANE_W +: LANE_W] == SMAX ||
                        result[i*LANE_W +: LANE_W] == SMIN); // R5

                AST_USAT_CLAMP_VAL: assert property (@(posedge clk) disable iff (!rst_n)
                    in_valid && mode == 2'b10
                    |=> !sat_flags[i] || result[i*LANE_W +: LANE_W] == '0 ||
                        result[i*LANE_W +: LANE_W] == '1); // R7
            end
        end
    end
endmodule

bind psa_addsub psa_addsub_chk #(
    .LANES    (LANES),
    .LANE_W   (LANE_W),
    .PARTITION(PARTITION),
    .OUT_REG  (OUT_REG)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op_sub   (op_sub),
    .mode     (mode),
    .opa      (opa),
    .opb      (opb),
    .out_valid(out_valid),
    .result   (result),
    .sat_flags(sat_flags)
);

// File: tb/psa_addsub_bench.sv
module psa_addsub_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        out_valid, f_valid;
    logic [63:0] result, f_result;
    logic [3:0]  sat_flags, f_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    psa_addsub u_psa_addsub (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .mode(mode), .opa(opa), .opb(opb),
        .out_valid(out_valid), .result(result), .sat_flags(sat_flags)
    );

    psa_addsub #(.PARTITION(1'b0)) u_psa_addsub_flat (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .mode(mode), .opa(opa), .opb(opb),
        .out_valid(f_valid), .result(f_result), .sat_flags(f_flags)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        sub;
        logic [1:0]  md;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] r;
        logic [3:0]  f;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // R4 / R3: wrap add; lane1 carry must not reach lane2
        '{8'd4, 1'b0, 2'b00, 64'h0001_7FFF_FFFF_1234, 64'h0001_0001_0001_1111, 64'h0002_8000_0000_2345, 4'b0000},
        // R4 / R3: wrap subtract; lane1 borrow must not reach lane2
        '{8'd3, 1'b1, 2'b00, 64'h0000_0005_0000_8000, 64'h0001_0003_0001_0001, 64'hFFFF_0002_FFFF_7FFF, 4'b0000},
        // R5: signed add clamps
        '{8'd5, 1'b0, 2'b01, 64'h7FFF_8000_4000_0010, 64'h0001_FFFF_4000_FFF0, 64'h7FFF_8000_7FFF_0000, 4'b1110},
        // R6: mixed signs never clamp
        '{8'd6, 1'b0, 2'b01, 64'h7FFF_8000_0001_FFFF, 64'h8000_7FFF_FFFF_0001, 64'hFFFF_FFFF_0000_0000, 4'b0000},
        // R5: signed subtract clamps
        '{8'd5, 1'b1, 2'b01, 64'h8000_7FFF_0000_0005, 64'h0001_FFFF_8000_0007, 64'h8000_7FFF_7FFF_FFFE, 4'b1110},
        // R7: signed a plus unsigned b
        '{8'd7, 1'b0, 2'b10, 64'h7FFF_FFFF_8000_0010, 64'hFFFF_0001_0005_0020, 64'hFFFF_0000_0000_0030, 4'b1010},
        // R11: add zero in unsigned-sat mode
        '{8'd11, 1'b0, 2'b10, 64'h8000_FFFF_7FFF_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_7FFF_0000, 4'b1100},
        // R7: signed a minus unsigned b
        '{8'd7, 1'b1, 2'b10, 64'h0010_0010_7FFF_8000, 64'h0005_0020_0000_0001, 64'h000B_0000_7FFF_0000, 4'b0101},
        // R9 / R8: mode 11 wraps, no flags
        '{8'd9, 1'b0, 2'b11, 64'h7FFF_8000_4000_0010, 64'h0001_FFFF_4000_FFF0, 64'h8000_7FFF_8000_0000, 4'b0000}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic s, input logic [1:0] m,
                         input logic [63:0] a, input logic [63:0] b);
        in_valid = v;
        op_sub   = s;
        mode     = m;
        opa      = a;
        opb      = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        in_valid = 1'b1;
        opa = 64'h1111_1111_1111_1111;
        opb = 64'h2222_2222_2222_2222;
        @(negedge clk);
        // R1: reset holds outputs at zero even with valid inputs
        check("R1 out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 result", result, 64'd0);
        check("R1 sat_flags", {60'd0, sat_flags}, 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].sub, VECS[i].md, VECS[i].a, VECS[i].b);
            check($sformatf("R%0d vec%0d result", VECS[i].req, i), result, VECS[i].r);
            check($sformatf("R8 vec%0d flags", i), {60'd0, sat_flags}, {60'd0, VECS[i].f});
            check($sformatf("R2 vec%0d out_valid", i), {63'd0, out_valid}, 64'd1);
        end

        // R2: idle cycles hold the last result and drop out_valid
        drive(1'b0, 1'b0, 2'b00, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111);
        check("R2 idle out_valid", {63'd0, out_valid}, 64'd0);
        check("R2 idle hold result", result, 64'h8000_7FFF_8000_0000);
        drive(1'b0, 1'b1, 2'b01, 64'h7FFF_7FFF_7FFF_7FFF, 64'h8000_8000_8000_8000);
        check("R2 idle hold result 2", result, 64'h8000_7FFF_8000_0000);

        // R10: unpartitioned instance carries across lanes, ignores mode
        drive(1'b1, 1'b0, 2'b01, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_0000_0001);
        check("R10 flat add carry", f_result, 64'h0000_0000_8000_0000);
        check("R10 flat flags", {60'd0, f_flags}, 64'd0);
        check("R3 packed same inputs", result, 64'h0000_0000_7FFF_0000);
        drive(1'b1, 1'b1, 2'b10, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001);
        check("R10 flat sub borrow", f_result, 64'h0000_0000_FFFF_FFFF);
        check("R10 flat flags sub", {60'd0, f_flags}, 64'd0);

        // R4: wrap sub of max negative by one per lane
        drive(1'b1, 1'b1, 2'b00, 64'h8000_8000_0000_0000, 64'h0001_0001_0001_0001);
        check("R4 wrap sub", result, 64'h7FFF_7FFF_FFFF_FFFF);
        check("R8 wrap flags", {60'd0, sat_flags}, 64'd0);

        // R1: reset asserted mid-run clears outputs
        rst_n = 1'b0;
        #1;
        check("R1 async clear", result, 64'd0);
        check("R1 async clear valid", {63'd0, out_valid}, 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule